// File: doc/BRIEF.md
# Prescaled Timer with Alarm and Interrupt Gating

This block keeps a 32-bit up-counter that advances once for every 128 core clock cycles. A compare register holds an alarm value. When a prescaled tick carries the counter onto that value, the block latches interrupt source 0. The other bits of the same pending register are set by peripheral interrupt inputs. Software clears pending bits by writing ones. An enable mask selects which pending bits drive the single interrupt output.

Software reaches the counter, the alarm, the pending register and the enable mask over a plain write strobe with an address and write data. Read data is a combinational function of the address. A write to the counter loads a new value and restarts the prescaler. This lets software line up the next tick exactly. Which sources exist, how they are vectored and how they are prioritised is decided outside this block.

Top module: `prescaled_alarm_timer`

## Requirements
- R1: After reset, the counter, alarm, pending and enable registers all read zero and `irq_out` is low.
- R2: Without writes, the counter holds its value and increases by exactly one on every 128th clock edge.
- R3: A write to offset 0x10 loads the counter on that edge and restarts the prescaler. The loaded value holds for 127 more edges and increases by one on the 128th edge after the write.
- R4: A tick at counter value 0xFFFFFFFF wraps the counter to 0.
- R5: A tick that moves the counter onto the alarm value (offset 0x14) sets pending bit 0 on the same edge, whatever the enable mask holds.
- R6: Pending bit 0 is set only by a tick. Writing the counter to equal the alarm does not set it. Clearing it while the counter rests at the alarm value keeps it clear.
- R7: Writing to the pending register (offset 0x38) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: If a source sets a pending bit on the same edge that a write clears it, the bit ends up set.
- R9: Pending bits latch whether or not they are enabled. Disabling a bit leaves it pending.
- R10: The enable register (offset 0x3C) reads back the last written mask. `irq_out` is high exactly when some bit is both pending and enabled.
- R11: A high `periph_irq[k]` on an edge sets pending bit k (k = 1..31). Bit 18 (mask 0x40000) is the position of the legacy disk interface source.
- R12: A read at any offset other than 0x10, 0x14, 0x38 and 0x3C returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| periph_irq | input | 31 | Peripheral sources for pending bits 31..1, pulse or level |
| irq_out | output | 1 | OR over pending AND enabled bits |

## Verification
Register writes and peripheral inputs take effect on the edge where they are sampled. Read data and `irq_out` follow combinationally. The bench therefore drives at the falling edge and samples just after the next rising edge, or at the next falling edge. A counter load shows its first increment 128 edges after the write edge. The bench waits 127 edges to confirm the value still holds, then one more edge to see the step. An alarm match is set on that same 128th edge, so the bench samples pending bit 0 on both sides of it.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned PTMR_PRESCALE = 128;
  localparam int unsigned PTMR_CNT_W    = 32;
  localparam int unsigned PTMR_NSRC     = 32;
  localparam int unsigned PTMR_ADDR_W   = 8;

  localparam logic [PTMR_ADDR_W-1:0] OFS_COUNT = 8'h10;
  localparam logic [PTMR_ADDR_W-1:0] OFS_ALARM = 8'h14;
  localparam logic [PTMR_ADDR_W-1:0] OFS_PEND  = 8'h38;
  localparam logic [PTMR_ADDR_W-1:0] OFS_MASK  = 8'h3C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_COUNT, SEL_ALARM, SEL_PEND, SEL_MASK
  } ptmr_sel_e;
endpackage

// File: rtl/ptmr_prescale_counter.sv
module ptmr_prescale_counter #(
  parameter int unsigned PRESCALE = 128,
  parameter int unsigned TW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] count,
  output logic [TW-1:0] count_next,
  output logic          step
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  function automatic logic [TW-1:0] count_succ(input logic [TW-1:0] v);
    return v + TW'(1);
  endfunction

  logic [PW-1:0] pre_q;
  logic [TW-1:0] count_q;
  logic          pre_last;

  assign pre_last   = (int'(pre_q) == int'(PRESCALE) - 1);
  assign step       = pre_last & ~load;
  assign count      = count_q;
  assign count_next = count_succ(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      count_q <= '0;
    end else if (load) begin
      pre_q   <= '0;
      count_q <= load_val;
    end else if (pre_last) begin
      pre_q   <= '0;
      count_q <= count_succ(count_q);
    end else begin
      pre_q   <= pre_q + PW'(1);
    end
  end

  assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre_q) < int'(PRESCALE));
  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_last && !load) |=> $stable(count_q));
  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (count_q - $past(count_q)) == TW'(1));
  assert_load_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_val) && pre_q == '0));
endmodule

// File: rtl/ptmr_alarm_cmp.sv
module ptmr_alarm_cmp #(
  parameter int unsigned TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alarm_we,
  input  logic [TW-1:0] alarm_wval,
  input  logic          step,
  input  logic [TW-1:0] count_next,
  output logic [TW-1:0] alarm_val,
  output logic          hit
);
  logic [TW-1:0] alarm_q;

  function automatic logic lands_on(input logic [TW-1:0] upcoming,
                                    input logic [TW-1:0] target);
    return upcoming == target;
  endfunction

  assign alarm_val = alarm_q;
  assign hit       = step & lands_on(count_next, alarm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alarm_q <= '0;
    else if (alarm_we) alarm_q <= alarm_wval;
  end

  assert_alarm_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_we |=> $stable(alarm_q));
endmodule

// File: rtl/ptmr_irq_ctrl.sv
module ptmr_irq_ctrl #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_mask,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wval,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] en,
  output logic            irq
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] clr_eff;

  function automatic logic [NSRC-1:0] w1c_next(input logic [NSRC-1:0] cur,
                                               input logic [NSRC-1:0] setv,
                                               input logic [NSRC-1:0] clrv);
    return (cur & ~clrv) | setv;
  endfunction

  assign clr_eff = clr_we ? clr_mask : '0;
  assign pend    = pend_q;
  assign en      = en_q;
  assign irq     = |(pend_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= w1c_next(pend_q, set_vec, clr_eff);
      if (en_we) en_q <= en_wval;
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend_q & $past(clr_mask & ~set_vec)) == '0));
  assert_only_sources_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));
  assert_enable_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q));
endmodule

// File: rtl/prescaled_alarm_timer.sv
module prescaled_alarm_timer
  import ptmr_pkg::*;
#(
  parameter int unsigned PRESCALE = PTMR_PRESCALE,
  parameter int unsigned TW       = PTMR_CNT_W,
  parameter int unsigned NSRC     = PTMR_NSRC,
  parameter int unsigned AW       = PTMR_ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [TW-1:0]   bus_wdata,
  output logic [TW-1:0]   bus_rdata,
  input  logic [NSRC-1:1] periph_irq,
  output logic            irq_out
);
  ptmr_sel_e       sel;
  logic            count_we, alarm_we, pend_we, mask_we;
  logic [TW-1:0]   count, count_next, alarm_val;
  logic            cnt_step, alarm_hit;
  logic [NSRC-1:0] src_set, pend, en;

  always_comb begin
    case (bus_addr)
      OFS_COUNT: sel = SEL_COUNT;
      OFS_ALARM: sel = SEL_ALARM;
      OFS_PEND:  sel = SEL_PEND;
      OFS_MASK:  sel = SEL_MASK;
      default:   sel = SEL_NONE;
    endcase
  end

  assign count_we = bus_we && (sel == SEL_COUNT);
  assign alarm_we = bus_we && (sel == SEL_ALARM);
  assign pend_we  = bus_we && (sel == SEL_PEND);
  assign mask_we  = bus_we && (sel == SEL_MASK);

  ptmr_prescale_counter #(.PRESCALE(PRESCALE), .TW(TW)) u_counter (
    .clk(clk), .rst_n(rst_n), .load(count_we), .load_val(bus_wdata),
    .count(count), .count_next(count_next), .step(cnt_step));

  ptmr_alarm_cmp #(.TW(TW)) u_alarm (
    .clk(clk), .rst_n(rst_n), .alarm_we(alarm_we), .alarm_wval(bus_wdata),
    .step(cnt_step), .count_next(count_next), .alarm_val(alarm_val),
    .hit(alarm_hit));

  assign src_set = {periph_irq, alarm_hit};

  ptmr_irq_ctrl #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(src_set),
    .clr_we(pend_we), .clr_mask(NSRC'(bus_wdata)),
    .en_we(mask_we), .en_wval(NSRC'(bus_wdata)),
    .pend(pend), .en(en), .irq(irq_out));

  always_comb begin
    unique case (sel)
      SEL_COUNT: bus_rdata = count;
      SEL_ALARM: bus_rdata = alarm_val;
      SEL_PEND:  bus_rdata = TW'(pend);
      SEL_MASK:  bus_rdata = TW'(en);
      default:   bus_rdata = '0;
    endcase
  end

  assert_alarm_hit_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && !alarm_we && !pend_we) |=> (count == alarm_val && pend[0]));
  assert_alarm_only_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> $past(cnt_step));
  assert_unmapped_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/test_prescaled_alarm_timer.sv
module test_prescaled_alarm_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [31:1] periph_irq = '0;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] rd;

  always #(CLK_P/2) clk = ~clk;

  prescaled_alarm_timer i_prescaled_alarm_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_irq(periph_irq),
    .irq_out(irq_out));

  function automatic logic [31:0] model_pend(input logic [31:0] cur,
                                             input logic [31:0] setv,
                                             input logic [31:0] clrv);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = setv[b] ? 1'b1 : (clrv[b] ? 1'b0 : cur[b]);
    return r;
  endfunction

  function automatic logic model_irq(input logic [31:0] p, input logic [31:0] e);
    for (int b = 0; b < 32; b++) if (p[b] && e[b]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] mp, me, setv, clrv, r;
    logic [1:0]  kind;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    bus_read(8'h10, rd); check("R1 count", rd, 0);
    bus_read(8'h14, rd); check("R1 alarm", rd, 0);
    bus_read(8'h38, rd); check("R1 pend", rd, 0);
    bus_read(8'h3C, rd); check("R1 mask", rd, 0);
    check("R1 irq", {31'd0, irq_out}, 0);

    // R3 load then R2 steady ticking
    bus_write(8'h10, 32'd100);
    wait_edges(127); bus_read(8'h10, rd); check("R3 hold 127", rd, 100);
    wait_edges(1);   bus_read(8'h10, rd); check("R3 step at 128", rd, 101);
    wait_edges(127); bus_read(8'h10, rd); check("R2 hold", rd, 101);
    wait_edges(1);   bus_read(8'h10, rd); check("R2 next tick", rd, 102);

    // R5 alarm match on tick
    bus_write(8'h14, 32'h6F);
    bus_write(8'h10, 32'h6E);
    wait_edges(127); bus_read(8'h38, rd); check("R5 before match", rd & 1, 0);
    wait_edges(1);   bus_read(8'h38, rd); check("R5 pend bit0", rd & 1, 1);
    bus_read(8'h10, rd); check("R5 count at alarm", rd, 32'h6F);
    check("R9 masked irq low", {31'd0, irq_out}, 0);
    bus_write(8'h3C, 32'h1);
    #1; check("R10 irq high", {31'd0, irq_out}, 1);
    bus_read(8'h3C, rd); check("R10 mask readback", rd, 1);
    bus_write(8'h38, 32'h1);
    bus_read(8'h38, rd); check("R7 cleared", rd, 0);
    check("R7 irq low", {31'd0, irq_out}, 0);
    // R6 no refire while resting at the alarm value
    wait_edges(20); bus_read(8'h38, rd); check("R6 no refire", rd, 0);
    bus_write(8'h10, 32'h6F);
    wait_edges(5); bus_read(8'h38, rd); check("R6 load equal no fire", rd, 0);
    wait_edges(125); bus_read(8'h38, rd); check("R6 next tick no fire", rd, 0);

    // R4 wrap, alarm at zero
    bus_write(8'h14, 32'h0);
    bus_write(8'h10, 32'hFFFF_FFFF);
    wait_edges(127); bus_read(8'h10, rd); check("R4 before wrap", rd, 32'hFFFF_FFFF);
    wait_edges(1); bus_read(8'h10, rd); check("R4 wrapped", rd, 0);
    bus_read(8'h38, rd); check("R5 alarm at wrap", rd & 1, 1);
    bus_write(8'h38, 32'hFFFF_FFFF);

    // R12 unmapped
    bus_read(8'h20, rd); check("R12 unmapped", rd, 0);
    bus_read(8'h3B, rd); check("R12 unaligned", rd, 0);

    // R11 legacy disk source, bit 18
    bus_write(8'h3C, 32'h0004_0000);
    @(negedge clk); periph_irq[18] = 1'b1;
    @(posedge clk); @(negedge clk); periph_irq[18] = 1'b0;
    bus_read(8'h38, rd); check("R11 bit18 pending", rd, 32'h0004_0000);
    check("R11 irq", {31'd0, irq_out}, 1);
    bus_write(8'h3C, 32'h0);
    bus_read(8'h38, rd); check("R9 stays pending", rd, 32'h0004_0000);
    check("R9 irq off", {31'd0, irq_out}, 0);
    bus_write(8'h38, 32'h0000_0001);
    bus_read(8'h38, rd); check("R7 zero bits untouched", rd, 32'h0004_0000);
    bus_write(8'h38, 32'hFFFF_FFFF);

    // R8 set wins over clear
    @(negedge clk);
    periph_irq[5] = 1'b1; bus_we = 1'b1; bus_addr = 8'h38; bus_wdata = 32'h20;
    @(posedge clk); @(negedge clk);
    periph_irq[5] = 1'b0; bus_we = 1'b0;
    bus_read(8'h38, rd); check("R8 set wins", rd, 32'h20);
    bus_write(8'h38, 32'hFFFF_FFFF);

    // random mix: keep the alarm out of reach
    bus_write(8'h14, 32'hFFFF_0000);
    bus_write(8'h10, 32'h0);
    mp = 32'h0; me = 32'h0;
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      bus_we = 1'b0;
      bus_read(8'h38, r);
      check("R7 R8 R11 random pend", r, mp);
      check("R10 random irq", {31'd0, irq_out}, {31'd0, model_irq(mp, me)});
      setv = $urandom & $urandom & $urandom;
      setv[0] = 1'b0;
      periph_irq = setv[31:1];
      kind = 2'($urandom_range(0, 2));
      bus_wdata = $urandom;
      clrv = 32'h0;
      if (kind == 2'd1) begin bus_we = 1'b1; bus_addr = 8'h38; clrv = bus_wdata; end
      else if (kind == 2'd2) begin bus_we = 1'b1; bus_addr = 8'h3C; end
      @(posedge clk);
      mp = model_pend(mp, setv, clrv);
      if (kind == 2'd2) me = bus_wdata;
    end
    @(negedge clk);
    bus_we = 1'b0; periph_irq = '0;
    bus_read(8'h3C, rd); check("R10 final mask", rd, me);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule